// File: doc/BRIEF.md
# Pipelined Address Bus Arbiter

This block decides which master may drive a shared system address bus whose address and data phases are split. Seven masters compete: three external ones (indices 0 to 2) and four internal ones, namely the core (3), the communications engine (4), the refresh controller (5) and the bridge (6). Each master has a request input and a grant output. The internal masters also present a request level alongside their request.

A grant is qualified. While an address tenure is running, no grant is shown. The next grant appears in the cycle after the running master's address acknowledge. When the bus is idle, the arbiter re-evaluates every cycle. A counter of data tenures still outstanding limits how far address tenures may run ahead. In zero-level mode nothing is granted while any data tenure is open. In one-level mode one open data tenure is allowed.

When no master is requesting, a configured master can be parked on the bus. A strap sampled during reset selects internal arbitration. In the other mode, external arbitration, this block stays silent.

Top module: `abus_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset when no master is parked, every bit of `gnt` is 0.
- R2: If `strap_int` is 0 during reset, `gnt` stays 0 until the next reset, whatever the requests, the parking settings or later values of `strap_int`.
- R3: At most one bit of `gnt` is 1 in any cycle.
- R4: `gnt` is 0 in a cycle where `addr_ack` is high during a running tenure. The next grant appears in the following cycle.
- R5: The grant goes to the pending request with the highest effective priority, where a larger value wins. The programmed priority of master i is `cfg_prio[i*PW +: PW]`. For internal master i (i >= 3), the effective priority is the larger of that value and its level `int_lvl[(i-3)*PW +: PW]`.
- R6: Equal effective priorities are resolved in favour of the lowest master index.
- R7: When `cfg_pipe_one` is 0, no grant is issued while a data tenure is outstanding. An acknowledge therefore yields no grant, and the waiting request is granted in the cycle after `data_done`.
- R8: When `cfg_pipe_one` is 1, a grant may follow an acknowledge while one data tenure is open. Once two are open, no grant is issued until a `data_done` brings the count back to one.
- R9: If no request is pending and `cfg_park_en` is 1, the grant of master `cfg_park_id` is held. A `cfg_park_id` of 7 or more parks nobody.
- R10: On an idle bus, a parked grant moves to a master that starts requesting, in the cycle after the request appears.
- R11: On an idle bus, a grant stays with its master while that master keeps requesting. The grant is dropped in the cycle after `addr_busy` is sampled high, or after its request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_int | input | 1 | Internal arbitration select, sampled only during reset |
| cfg_pipe_one | input | 1 | 1 selects one-level pipelining, 0 selects zero-level |
| cfg_park_en | input | 1 | Enables parking |
| cfg_park_id | input | 3 | Index of the parked master |
| cfg_prio | input | 14 | Programmed priority, PW bits per master |
| int_lvl | input | 8 | Request level of each internal master, PW bits each |
| req | input | 7 | Bus request, one bit per master |
| addr_ack | input | 1 | Address acknowledge of the running tenure, a single-cycle pulse |
| addr_busy | input | 1 | Address bus busy, driven by the tenure owner |
| data_done | input | 1 | Pulse at the end of a data tenure |
| gnt | output | 7 | Registered grant, one bit per master |

## Verification
A wrong outstanding-tenure count shows as a grant that appears too early or too late around `data_done`. This becomes visible in the very next cycle after the acknowledge or completion pulse in question. A wrong hold or clear decision shows at `gnt` one cycle after the `addr_busy` or request edge. A fault in the priority picker shows as the wrong bit being set in the cycle after the competing requests appear. A mode register that captured the strap wrongly shows up as grants in external mode, or no grants at all, from the first cycle after reset.

// File: rtl/abus_arb_pkg.sv
// Shared types for the address bus arbiter.
package abus_arb_pkg;
    // Arbitration mode captured from the strap during reset.
    typedef enum logic {
        ARB_EXT = 1'b0,
        ARB_INT = 1'b1
    } arb_mode_e;

    // What the grant register does at the next edge.
    typedef enum logic [1:0] {
        GACT_KEEP  = 2'd0,
        GACT_LOAD  = 2'd1,
        GACT_CLEAR = 2'd2
    } gnt_act_e;
endpackage

// File: rtl/abus_arb_prio.sv
// Priority picker. It forms an effective priority for each master and
// returns a one-hot winner among the pending requests.
// Assumes: the first N_EXT masters are external and take their programmed
// priority only; the rest are internal and use the larger of their
// programmed priority and their request level. Ties go to the lowest index.
module abus_arb_prio #(
    parameter int NM    = 7,
    parameter int N_EXT = 3,
    parameter int PW    = 2
) (
    input  logic [NM-1:0]            req,
    input  logic [NM*PW-1:0]         cfg_prio,
    input  logic [(NM-N_EXT)*PW-1:0] int_lvl,
    output logic                     any_req,
    output logic [NM-1:0]            win
);
    logic [PW-1:0] eff [NM];

    // Effective priority per master; the variant depends on the master kind.
    for (genvar i = 0; i < NM; i++) begin : g_eff
        if (i < N_EXT) begin : g_ext
            assign eff[i] = cfg_prio[i*PW +: PW];
        end else begin : g_int
            logic [PW-1:0] prg;
            logic [PW-1:0] lvl;
            assign prg    = cfg_prio[i*PW +: PW];
            assign lvl    = int_lvl[(i-N_EXT)*PW +: PW];
            assign eff[i] = (lvl > prg) ? lvl : prg;
        end
    end

    // Scan from the top index down; >= lets a lower index win a tie.
    always_comb begin
        logic [PW-1:0] best;
        best    = '0;
        win     = '0;
        any_req = |req;
        for (int j = NM - 1; j >= 0; j--) begin
            if (req[j] && (win == '0 || eff[j] >= best)) begin
                win    = '0;
                win[j] = 1'b1;
                best   = eff[j];
            end
        end
    end
endmodule

// File: rtl/abus_arb_depth.sv
// Counter of outstanding data tenures. It counts up on each address
// acknowledge and down on each data completion, saturating at both ends.
// It reports whether a new grant is allowed given the next count and the
// pipelining limit (0 or 1).
// Assumes: ack and done are single-cycle pulses and may coincide.
module abus_arb_depth #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          pipe_one,
    output logic [CW-1:0] pend_q,
    output logic          allow
);
    localparam logic [CW-1:0] PMAX = {CW{1'b1}};

    logic [CW-1:0] pend_nxt;
    logic [CW-1:0] limit;

    // Next count with saturation.
    always_comb begin
        pend_nxt = pend_q;
        if (inc && !dec && pend_q != PMAX) begin
            pend_nxt = pend_q + 1'b1;
        end else if (dec && !inc && pend_q != '0) begin
            pend_nxt = pend_q - 1'b1;
        end
    end

    // Grant permission from the count that will hold after this edge.
    always_comb begin
        limit = CW'(pipe_one);
        allow = (pend_nxt <= limit);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_nxt;
        end
    end
endmodule

// File: rtl/abus_arb_park.sv
// Park decoder. It turns the parked-master index into a one-hot vector.
// Assumes: an index of NM or more selects nobody.
module abus_arb_park #(
    parameter int NM = 7,
    parameter int IW = 3
) (
    input  logic          park_en,
    input  logic [IW-1:0] park_id,
    output logic [NM-1:0] park_vec
);
    // One comparator per master.
    for (genvar i = 0; i < NM; i++) begin : g_dec
        assign park_vec[i] = park_en && (park_id == IW'(i));
    end
endmodule

// File: rtl/abus_arb_grant.sv
// Grant register. It loads a candidate at an address acknowledge and on an
// idle bus. It clears while a tenure runs, and it holds a requester's grant
// until that master starts.
// Assumes: addr_ack comes no earlier than the second busy cycle of a tenure.
module abus_arb_grant
    import abus_arb_pkg::*;
#(
    parameter int NM = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          int_mode,
    input  logic          addr_ack,
    input  logic          addr_busy,
    input  logic          allow,
    input  logic          any_req,
    input  logic [NM-1:0] req,
    input  logic [NM-1:0] win,
    input  logic [NM-1:0] park_vec,
    output logic [NM-1:0] gnt_q
);
    gnt_act_e      act;
    logic [NM-1:0] cand;

    // Candidate: a requester first, otherwise the parked master, gated by depth.
    always_comb begin
        cand = '0;
        if (allow) begin
            cand = any_req ? win : park_vec;
        end
    end

    // Choose the update of the grant register.
    always_comb begin
        if (!int_mode) begin
            act = GACT_CLEAR;
        end else if (addr_ack) begin
            act = GACT_LOAD;
        end else if (addr_busy) begin
            act = GACT_CLEAR;
        end else if ((gnt_q & req) != '0) begin
            act = GACT_KEEP;
        end else begin
            act = GACT_LOAD;
        end
    end

    // Registered grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q <= '0;
        end else begin
            case (act)
                GACT_LOAD:  gnt_q <= cand;
                GACT_CLEAR: gnt_q <= '0;
                default:    gnt_q <= gnt_q;
            endcase
        end
    end
endmodule

// File: rtl/abus_arbiter.sv
// Address bus arbiter top. It captures the arbitration mode during reset
// and joins the picker, the park decoder, the depth counter and the grant
// register.
// Assumes: configuration inputs change only while no data tenure is open.
module abus_arbiter
    import abus_arb_pkg::*;
#(
    parameter int N_EXT = 3,
    parameter int N_INT = 4,
    parameter int PW    = 2,
    parameter int CW    = 2,
    localparam int NM   = N_EXT + N_INT,
    localparam int IW   = $clog2(NM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_int,
    input  logic                cfg_pipe_one,
    input  logic                cfg_park_en,
    input  logic [IW-1:0]       cfg_park_id,
    input  logic [NM*PW-1:0]    cfg_prio,
    input  logic [N_INT*PW-1:0] int_lvl,
    input  logic [NM-1:0]       req,
    input  logic                addr_ack,
    input  logic                addr_busy,
    input  logic                data_done,
    output logic [NM-1:0]       gnt
);
    arb_mode_e     mode_q;
    logic          int_mode;
    logic          any_req;
    logic          allow;
    logic [NM-1:0] win;
    logic [NM-1:0] park_vec;
    logic [CW-1:0] pend_cnt;

    // Mode is captured from the strap only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= arb_mode_e'(strap_int);
        end else begin
            mode_q <= mode_q;
        end
    end

    assign int_mode = (mode_q == ARB_INT);

    abus_arb_prio #(.NM(NM), .N_EXT(N_EXT), .PW(PW)) u_prio (
        .req      (req),
        .cfg_prio (cfg_prio),
        .int_lvl  (int_lvl),
        .any_req  (any_req),
        .win      (win)
    );

    abus_arb_park #(.NM(NM), .IW(IW)) u_park (
        .park_en  (cfg_park_en),
        .park_id  (cfg_park_id),
        .park_vec (park_vec)
    );

    abus_arb_depth #(.CW(CW)) u_depth (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (addr_ack),
        .dec      (data_done),
        .pipe_one (cfg_pipe_one),
        .pend_q   (pend_cnt),
        .allow    (allow)
    );

    abus_arb_grant #(.NM(NM)) u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_mode  (int_mode),
        .addr_ack  (addr_ack),
        .addr_busy (addr_busy),
        .allow     (allow),
        .any_req   (any_req),
        .req       (req),
        .win       (win),
        .park_vec  (park_vec),
        .gnt_q     (gnt)
    );
endmodule

// File: rtl/abus_arbiter_chk.sv
// Property checker for the address bus arbiter, attached by bind.
module abus_arbiter_chk #(
    parameter int NM = 7,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          int_mode,
    input logic          cfg_pipe_one,
    input logic          addr_ack,
    input logic          addr_busy,
    input logic [CW-1:0] pend_cnt,
    input logic [NM-1:0] gnt
);
    // R3
    onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R2
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_mode |-> (gnt == '0));

    // R4
    ack_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ack && $past(addr_busy) && !$past(addr_ack)) |-> (gnt == '0));

    // R4
    qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && $past(addr_busy)) |-> $past(addr_ack));

    // R7 R8
    depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> (pend_cnt <= CW'(cfg_pipe_one)));
endmodule

bind abus_arbiter abus_arbiter_chk #(.NM(NM), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .int_mode     (int_mode),
    .cfg_pipe_one (cfg_pipe_one),
    .addr_ack     (addr_ack),
    .addr_busy    (addr_busy),
    .pend_cnt     (pend_cnt),
    .gnt          (gnt)
);

// File: tb/sim_abus_arbiter.sv
// Directed bench for the address bus arbiter. Inputs are driven and
// outputs sampled at the falling edge.
module sim_abus_arbiter;
    localparam int NM = 7;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap_int = 1'b1;
    logic          cfg_pipe_one = 1'b0;
    logic          cfg_park_en = 1'b0;
    logic [2:0]    cfg_park_id = '0;
    logic [NM*PW-1:0] cfg_prio = '0;
    logic [4*PW-1:0]  int_lvl = '0;
    logic [NM-1:0] req = '0;
    logic          addr_ack = 1'b0;
    logic          addr_busy = 1'b0;
    logic          data_done = 1'b0;
    logic [NM-1:0] gnt;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    abus_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .strap_int(strap_int),
        .cfg_pipe_one(cfg_pipe_one), .cfg_park_en(cfg_park_en),
        .cfg_park_id(cfg_park_id), .cfg_prio(cfg_prio), .int_lvl(int_lvl),
        .req(req), .addr_ack(addr_ack), .addr_busy(addr_busy),
        .data_done(data_done), .gnt(gnt)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [NM-1:0] exp);
        n_chk++;
        if (gnt !== exp) begin
            n_err++;
            $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0;
        strap_int = strap;
        req = '1;
        tick(); tick();
        chk("R1 during reset", '0);
        req = '0;
        rst_n = 1'b1;
        tick();
        chk("R1 after reset", '0);
    endtask

    task automatic t_priority();
        cfg_prio = '0;
        int_lvl = '0;
        cfg_prio[1*PW +: PW] = 2'd1;
        cfg_prio[3*PW +: PW] = 2'd2;
        req = 7'b0001010;
        tick();
        chk("R5 programmed priority", 7'b0001000);
        req = '0;
        tick();
        chk("R11 withdrawn request", '0);
        int_lvl[1*PW +: PW] = 2'd3;
        req = 7'b0011000;
        tick();
        chk("R5 internal level", 7'b0010000);
        req = '0; tick();
        cfg_prio = '0; int_lvl = '0;
        req = 7'b1100100;
        tick();
        chk("R6 tie lowest index", 7'b0000100);
        req = '0; tick();
        cfg_prio[4*PW +: PW] = 2'd1;
        cfg_prio[6*PW +: PW] = 2'd1;
        req = 7'b1010000;
        tick();
        chk("R6 internal tie", 7'b0010000);
        req = '0; tick();
        cfg_prio = '0;
        req = '1;
        tick();
        n_chk++;
        if ($countones(gnt) != 1) begin
            n_err++;
            $display("FAIL R3 one grant: gnt=%b expected one bit", gnt);
        end
        req = '0; tick();
    endtask

    task automatic t_pipe_one();
        cfg_pipe_one = 1'b1;
        req = 7'b0000001;
        tick();
        chk("R11 idle grant", 7'b0000001);
        addr_busy = 1'b1; req = 7'b0000010;
        tick();
        chk("R11 drop on busy", '0);
        addr_ack = 1'b1;
        #1;
        chk("R4 none in ack cycle", '0);
        tick();
        chk("R4 grant after ack", 7'b0000010);
        addr_ack = 1'b0; addr_busy = 1'b0;
        tick();
        chk("R11 hold while requesting", 7'b0000010);
        addr_busy = 1'b1; req = '0;
        tick();
        chk("R11 drop on start", '0);
        addr_ack = 1'b1; req = 7'b0000001;
        tick();
        chk("R8 second ack blocked", '0);
        addr_ack = 1'b0; addr_busy = 1'b0;
        tick();
        chk("R8 two open blocked", '0);
        data_done = 1'b1;
        tick();
        chk("R8 grant after done", 7'b0000001);
        data_done = 1'b0; req = '0;
        tick();
        data_done = 1'b1;
        tick();
        data_done = 1'b0;
        tick();
    endtask

    task automatic t_zero();
        cfg_pipe_one = 1'b0;
        req = 7'b0100000;
        tick();
        chk("R7 idle grant", 7'b0100000);
        addr_busy = 1'b1; req = '0;
        tick();
        addr_ack = 1'b1; req = 7'b1000000;
        tick();
        chk("R7 ack gives nothing", '0);
        addr_ack = 1'b0; addr_busy = 1'b0;
        tick(); tick();
        chk("R7 wait for data", '0);
        data_done = 1'b1;
        tick();
        chk("R7 grant after done", 7'b1000000);
        data_done = 1'b0; req = '0;
        tick();
        chk("R11 released", '0);
    endtask

    task automatic t_park();
        cfg_park_en = 1'b1; cfg_park_id = 3'd2;
        tick();
        chk("R9 parked", 7'b0000100);
        req = 7'b0010000;
        tick();
        chk("R10 park replaced", 7'b0010000);
        req = '0;
        tick();
        chk("R9 park back", 7'b0000100);
        cfg_park_id = 3'd7;
        tick();
        chk("R9 out of range", '0);
        cfg_park_en = 1'b0;
    endtask

    task automatic t_external();
        do_reset(1'b0);
        req = 7'b0000001; cfg_park_en = 1'b1; cfg_park_id = 3'd1;
        tick(); tick();
        chk("R2 external quiet", '0);
        strap_int = 1'b1;
        tick(); tick();
        chk("R2 strap ignored", '0);
        req = '0; cfg_park_en = 1'b0;
        do_reset(1'b1);
    endtask

    initial begin
        tick();
        do_reset(1'b1);
        t_priority();
        t_pipe_one();
        t_zero();
        t_park();
        t_external();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule